// File: doc/BRIEF.md
# Cascaded Capture Timer with Coherent Timestamp

This block is a free-running counter made from two equal halves. The upper half steps only on the cycle in which the lower half rolls over. Together they form one wide count. A single asynchronous capture pin is brought into the counting clock domain. Each rising edge on that pin then copies the whole count, both halves together, into one capture register. Because both halves load on the same clock edge, a timestamp can never pair a lower word from after a rollover with an upper word from before it.

Software reads the captured value, sees a valid flag, and acknowledges it. If a second capture lands before that acknowledge, a sticky overrun flag records the lost value. A one-cycle flag marks each rollover of the full count from all ones back to zero. A clear input zeroes both halves on the same edge. An enable input freezes the count, but captures keep working while it is frozen.

Top module: `cascade_capture_timer`

## Requirements
- R1: After a cycle with `rst` high, `cap_valid`, `overrun` and `wrap_pulse` are 0 and the count is zero. `rst` is synchronous and active high.
- R2: While `en` is high, the lower half adds one each cycle. The upper half adds one only in the cycle where the lower half steps from all ones to zero, so the pair counts as a single 2*HALF_W-bit value.
- R3: Take three successive clock edges e1, e2 and e3, where e1 is the first edge at which `cap_in` is seen high after being low. `cap_value` then holds the count that was present just after e2, and `cap_valid` is high from e3 on.
- R4: A capture taken while the lower half rolls over returns a matching upper and lower word. Examples: lower all ones with the old upper word, or lower zero with the new upper word.
- R5: Only a low-to-high change on `cap_in` captures. Holding `cap_in` high starts no further captures, and the captured value stays until the next capture.
- R6: `ack` high in a cycle with no new capture clears `cap_valid` at the next edge. `cap_value` is left unchanged.
- R7: A capture that occurs while `cap_valid` is high and `ack` is low sets `overrun`. The new value replaces the old one. `overrun` stays high until reset.
- R8: `clr` high zeroes both halves at the same edge, whatever the state of `en`.
- R9: While `en` is low, the count holds. A capture in that time returns the held count.
- R10: `wrap_pulse` is high for exactly the one cycle in which the count reads zero after stepping from all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | counting clock |
| rst | input | 1 | synchronous reset, active high |
| clr | input | 1 | zero both halves |
| en | input | 1 | count enable |
| cap_in | input | 1 | asynchronous capture trigger |
| ack | input | 1 | acknowledge of the captured value |
| cap_value | output | 2*HALF_W | captured count |
| cap_valid | output | 1 | captured value not yet acknowledged |
| overrun | output | 1 | sticky: a capture overwrote an unread value |
| wrap_pulse | output | 1 | one-cycle flag on full-count rollover |

## Verification
The bench fires capture edges in four situations: a plain running count, the counts just before and just after a lower-half rollover, a frozen count, and the count right after a clear. Each expected timestamp comes from the stated latency of two edges. An offset error shows up in the plain case, a split between the halves shows up at the rollover, and a wrong hold or clear shows up in the frozen and cleared cases. A trigger held high across an acknowledge, and a double capture with no acknowledge in between, separate true edge detection and overrun tracking from capturing on the level. A run through the full count rollover compares the wrap flag against an independent model on every cycle.

// File: rtl/cct_sync_edge.sv
module cct_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sr;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      prev <= 1'b0;
    end else begin
      sr   <= {sr[STAGES-2:0], din};
      prev <= sr[STAGES-1];
    end
  end

  assign rise = sr[STAGES-1] & ~prev;

  // R5
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/cct_half_counter.sv
module cct_half_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         carry
);
  localparam logic [W-1:0] TOP = '1;

  assign carry = inc && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc)
      cnt <= cnt + 1'b1;
  end

  // R2
  half_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/cascade_capture_timer.sv
module cascade_capture_timer #(
  parameter int HALF_W    = 16,
  parameter int SYNC_LEN  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  en,
  input  logic                  cap_in,
  input  logic                  ack,
  output logic [2*HALF_W-1:0]   cap_value,
  output logic                  cap_valid,
  output logic                  overrun,
  output logic                  wrap_pulse
);
  localparam int NUM   = 2;
  localparam int CNT_W = NUM * HALF_W;

  logic [HALF_W-1:0] half [NUM];
  logic [NUM:0]      chain;
  logic [CNT_W-1:0]  count;
  logic              rise;

  assign chain[0] = en;

  for (genvar g = 0; g < NUM; g++) begin : g_half
    cct_half_counter #(.W(HALF_W)) u_half (
      .clk   (clk),
      .rst   (rst),
      .clr   (clr),
      .inc   (chain[g]),
      .cnt   (half[g]),
      .carry (chain[g+1])
    );
    assign count[g*HALF_W +: HALF_W] = half[g];
  end

  cct_sync_edge #(.STAGES(SYNC_LEN)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (cap_in),
    .rise (rise)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_value <= '0;
      cap_valid <= 1'b0;
      overrun   <= 1'b0;
    end else if (rise) begin
      cap_value <= count;
      cap_valid <= 1'b1;
      if (cap_valid && !ack)
        overrun <= 1'b1;
    end else if (ack) begin
      cap_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      wrap_pulse <= 1'b0;
    else
      wrap_pulse <= chain[NUM] && !clr;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!cap_valid && !overrun && !wrap_pulse && count == '0));
  // R3
  capture_coherent_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> (cap_valid && cap_value == $past(count)));
  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !rise) |=> (!cap_valid && $stable(cap_value)));
  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  // R8
  clear_both_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));
  // R9
  hold_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(count));
  // R10
  wrap_single_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_pulse |-> (count == '0) ##1 !wrap_pulse);
endmodule

// File: tb/cascade_capture_timer_test.sv
module cascade_capture_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic        en  = 1'b0;
  logic        cap_in = 1'b0;
  logic        ack = 1'b0;
  logic [15:0] cap_value;
  logic        cap_valid, overrun, wrap_pulse;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [15:0] model_cnt = '0;
  logic        model_wrap = 1'b0;
  logic        cv_prev = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  cascade_capture_timer #(.HALF_W(8)) uut (
    .clk(clk), .rst(rst), .clr(clr), .en(en), .cap_in(cap_in), .ack(ack),
    .cap_value(cap_value), .cap_valid(cap_valid), .overrun(overrun),
    .wrap_pulse(wrap_pulse)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference count from R2, R8, R9, R10
  always @(posedge clk) begin
    if (rst || clr) model_cnt <= '0;
    else if (en)    model_cnt <= model_cnt + 16'd1;
    model_wrap <= !rst && !clr && en && (model_cnt == 16'hFFFF);
  end

  // monitor: scoreboard pops on each fresh capture
  always @(negedge clk) begin
    if (!rst && cap_valid && !cv_prev) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected capture", {16'd0, cap_value}, 32'd0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(cap_value == e, t, {16'd0, cap_value}, {16'd0, e});
      end
    end
    if (!rst && wrap_pulse !== model_wrap)
      chk(1'b0, "R10 wrap flag", {31'd0, wrap_pulse}, {31'd0, model_wrap});
    cv_prev <= cap_valid;
  end

  // driver: caller stands at a negedge; R3 latency gives count after e2
  task automatic cap_ack(input string tag);
    logic [15:0] e;
    e = en ? model_cnt + 16'd2 : model_cnt;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    cap_in = 1'b1;
    repeat (4) @(negedge clk);
    cap_in = 1'b0;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(cap_valid == 1'b0, "R6 valid cleared", {31'd0, cap_valid}, 32'd0);
    chk(cap_value == e, "R6 value kept", {16'd0, cap_value}, {16'd0, e});
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [15:0] e1, e2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!cap_valid && !overrun && !wrap_pulse, "R1 reset state",
        {29'd0, cap_valid, overrun, wrap_pulse}, 32'd0);
    en = 1'b1;
    repeat (5) @(negedge clk);
    cap_ack("R3 plain capture");

    while (model_cnt[7:0] != 8'hFD) @(negedge clk);
    cap_ack("R4 before rollover (R2 chain)");
    while (model_cnt[7:0] != 8'hFE) @(negedge clk);
    cap_ack("R4 after rollover (R2 chain)");

    en = 1'b0;
    repeat (3) @(negedge clk);
    cap_ack("R9 held count");
    en = 1'b1;
    repeat (7) @(negedge clk);

    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    cap_ack("R8 after clear");

    // R7 double capture without ack; R5 level held
    e1 = model_cnt + 16'd2;
    exp_q.push_back(e1);
    tag_q.push_back("R7 first capture");
    cap_in = 1'b1;
    repeat (4) @(negedge clk);
    cap_in = 1'b0;
    repeat (3) @(negedge clk);
    e2 = model_cnt + 16'd2;
    cap_in = 1'b1;
    repeat (3) @(negedge clk);
    chk(overrun == 1'b1, "R7 overrun set", {31'd0, overrun}, 32'd1);
    chk(cap_value == e2, "R7 new value", {16'd0, cap_value}, {16'd0, e2});
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    repeat (5) @(negedge clk);
    chk(cap_valid == 1'b0, "R5 no recapture on level", {31'd0, cap_valid}, 32'd0);
    chk(cap_value == e2, "R5 value held", {16'd0, cap_value}, {16'd0, e2});
    chk(overrun == 1'b1, "R7 overrun sticky", {31'd0, overrun}, 32'd1);
    cap_in = 1'b0;
    repeat (3) @(negedge clk);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!overrun && !cap_valid, "R1 reset clears overrun",
        {30'd0, overrun, cap_valid}, 32'd0);

    while (model_cnt != 16'hFFF0) @(negedge clk);
    while (!wrap_pulse) @(negedge clk);
    chk(model_cnt == 16'h0000, "R10 wrap at zero", {16'd0, model_cnt}, 32'd0);
    @(negedge clk);
    chk(wrap_pulse == 1'b0, "R10 one cycle", {31'd0, wrap_pulse}, 32'd0);
    chk(exp_q.size() == 0, "R3 all captures seen", exp_q.size(), 32'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule